// File: doc/BRIEF.md
# Shared-Bus Fabric with Pipelined Arbitration

This block joins several bus masters to several slaves over one shared pipelined bus. A fixed-priority arbiter chooses which master owns the address phase. A decoder picks a slave from the top address bits. The address, control and write-data lines of the owning master pass to every slave. The read data, ready and response of the selected slave pass back to every master. Address and data phases overlap: the write data comes from the master that owned the previous address phase, so one master can issue an address while another finishes its data transfer.

A slave may answer OKAY, ERROR or SPLIT. A master answered with SPLIT is removed from arbitration until its bit in the resume vector is raised. When no eligible master is requesting, the bus parks on master 0, and its transfer type is forced to idle. Transfer encoding: IDLE = 00, NONSEQ = 10. Response encoding: OKAY = 00, ERROR = 01, SPLIT = 11.

Top module: `bus_fabric`

## Requirements
- R1: `s_sel_o` is one-hot and selects the slave whose number equals the top clog2(N_SLV) bits of `s_addr_o`. With 4 slaves and 16-bit addresses, bits [15:14] = 01 select slave 1.
- R2: At an update edge, the requesting eligible master with the lowest index is granted. `m_grant_o` is one-hot with that bit set, and `m_owner_o` holds its index.
- R3: If no eligible master requests, master 0 is granted and `s_trans_o` is forced to IDLE (00), whatever master 0 drives.
- R4: Grant and owner change only on a clock edge where `m_ready_o` is high. While a slave holds ready low, they stay as they are.
- R5: `s_addr_o`, `s_write_o` and `s_trans_o` (when not parked) are those of the master in `m_owner_o`.
- R6: `s_wdata_o` is the write data of the master that owned the address phase ending at the last ready edge.
- R7: `m_rdata_o`, `m_ready_o` and `m_resp_o` come from the slave addressed in the last accepted non-idle address phase. When the data phase is idle, they are ready = 1, response OKAY and data 0.
- R8: A SPLIT (11) response accepted with ready high masks that master from arbitration at that same edge. The mask holds until the master's bit in `split_resume_i` is high; that edge may grant the master again.
- R9: An ERROR (01) response is passed to the masters and does not remove the master from arbitration.
- R10: While `rst_ni` is low, every output is zero whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_req_i | input | N_MST | Bus request per master |
| m_addr_i | input | N_MST*AW | Address per master, master j at [j*AW +: AW] |
| m_trans_i | input | N_MST*2 | Transfer type per master |
| m_write_i | input | N_MST | Write flag per master |
| m_wdata_i | input | N_MST*DW | Write data per master |
| split_resume_i | input | N_MST | Resume bit per split master |
| m_grant_o | output | N_MST | One-hot grant |
| m_owner_o | output | clog2(N_MST) | Index of the address-phase owner |
| m_rdata_o | output | DW | Read data to masters |
| m_ready_o | output | 1 | Transfer-done flag to masters and slaves |
| m_resp_o | output | 2 | Response to masters |
| s_sel_o | output | N_SLV | One-hot slave select |
| s_addr_o | output | AW | Shared address |
| s_trans_o | output | 2 | Shared transfer type |
| s_write_o | output | 1 | Shared write flag |
| s_wdata_o | output | DW | Shared write data |
| s_rdata_i | input | N_SLV*DW | Read data per slave |
| s_ready_i | input | N_SLV | Ready per slave |
| s_resp_i | input | N_SLV*2 | Response per slave |

## Verification
The assertions check these rules on every cycle: the grant is one-hot and agrees with the owner index, the grant holds while ready is low, the transfer type is idle while the bus is parked, the slave select is one-hot, the write-data source lags the owner by one ready edge, a split master is never granted at the next edge, and all outputs are zero during reset. Only the bench scenarios can show the end-to-end data paths. These are: which slave's read data reaches the masters for a given address, the exact data hand-over between two masters in back-to-back phases, the stall-then-release sequence, and the full split, hold and resume cycle with its timing.

// File: rtl/bus_fabric_pkg.sv
package bus_fabric_pkg;
  typedef enum logic [1:0] {TR_IDLE = 2'b00, TR_BUSY = 2'b01, TR_NSEQ = 2'b10, TR_SEQ = 2'b11} trans_e;
  typedef enum logic [1:0] {RSP_OKAY = 2'b00, RSP_ERROR = 2'b01, RSP_RETRY = 2'b10, RSP_SPLIT = 2'b11} resp_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bfab_arbiter.sv
module bfab_arbiter #(
  parameter int N_MST = 3,
  parameter int MW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             ready_i,
  input  logic [N_MST-1:0] split_set_i,
  input  logic [N_MST-1:0] resume_i,
  output logic [N_MST-1:0] grant_o,
  output logic [MW-1:0]    owner_o,
  output logic             park_o
);
  logic [N_MST-1:0] mask_q, mask_eff, elig;
  logic [MW-1:0]    win;
  logic             found;

  // a split seen at this edge masks immediately; resume unmasks at its edge
  assign mask_eff = (mask_q & ~resume_i) | split_set_i;
  assign elig     = req_i & ~mask_eff;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win   = MW'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      grant_o <= '0;
      owner_o <= '0;
      park_o  <= 1'b0;
    end else begin
      mask_q <= mask_eff;
      if (ready_i) begin
        owner_o <= win;
        grant_o <= found ? (N_MST'(1) << win) : N_MST'(1);
        park_o  <= !found;
      end
    end
  end
endmodule

// File: rtl/bfab_decoder.sv
module bfab_decoder #(
  parameter int N_SLV = 4,
  parameter int AW    = 16,
  parameter int SW    = 2
) (
  input  logic [AW-1:0]    addr_i,
  output logic [SW-1:0]    idx_o,
  output logic [N_SLV-1:0] sel_o
);
  assign idx_o = addr_i[AW-1 -: SW];
  assign sel_o = N_SLV'(1) << idx_o;
endmodule

// File: rtl/bfab_datapath.sv
module bfab_datapath
  import bus_fabric_pkg::*;
#(
  parameter int N_MST = 3,
  parameter int N_SLV = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int MW    = 2,
  parameter int SW    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MW-1:0]      owner_i,
  input  logic               park_i,
  input  logic [SW-1:0]      slv_idx_i,
  input  logic [N_MST*AW-1:0] m_addr_i,
  input  logic [N_MST*2-1:0] m_trans_i,
  input  logic [N_MST-1:0]   m_write_i,
  input  logic [N_MST*DW-1:0] m_wdata_i,
  input  logic [N_SLV*DW-1:0] s_rdata_i,
  input  logic [N_SLV-1:0]   s_ready_i,
  input  logic [N_SLV*2-1:0] s_resp_i,
  output logic [AW-1:0]      a_addr_o,
  output logic [1:0]         a_trans_o,
  output logic               a_write_o,
  output logic [DW-1:0]      wdata_o,
  output logic [DW-1:0]      rdata_o,
  output logic               ready_o,
  output logic [1:0]         resp_o,
  output logic [N_MST-1:0]   split_set_o,
  output logic [MW-1:0]      dph_mst_o
);
  logic          dph_v_q;
  logic [SW-1:0] dph_slv_q;
  logic [MW-1:0] dph_mst_q;

  assign a_addr_o  = m_addr_i[owner_i*AW +: AW];
  assign a_write_o = m_write_i[owner_i];
  assign a_trans_o = park_i ? TR_IDLE : m_trans_i[owner_i*2 +: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dph_v_q   <= 1'b0;
      dph_slv_q <= '0;
      dph_mst_q <= '0;
    end else if (ready_o) begin
      dph_v_q   <= a_trans_o[1];
      dph_slv_q <= slv_idx_i;
      dph_mst_q <= owner_i;
    end
  end

  assign wdata_o   = m_wdata_i[dph_mst_q*DW +: DW];
  assign ready_o   = dph_v_q ? s_ready_i[dph_slv_q] : 1'b1;
  assign rdata_o   = dph_v_q ? s_rdata_i[dph_slv_q*DW +: DW] : '0;
  assign resp_o    = dph_v_q ? s_resp_i[dph_slv_q*2 +: 2] : RSP_OKAY;
  assign dph_mst_o = dph_mst_q;
  assign split_set_o = (dph_v_q && ready_o && resp_o == RSP_SPLIT) ? (N_MST'(1) << dph_mst_q) : '0;
endmodule

// File: rtl/bus_fabric.sv
module bus_fabric
  import bus_fabric_pkg::*;
#(
  parameter int N_MST = 3,
  parameter int N_SLV = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int MW   = idx_w(N_MST),
  localparam int SW   = idx_w(N_SLV)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_MST-1:0]    m_req_i,
  input  logic [N_MST*AW-1:0] m_addr_i,
  input  logic [N_MST*2-1:0]  m_trans_i,
  input  logic [N_MST-1:0]    m_write_i,
  input  logic [N_MST*DW-1:0] m_wdata_i,
  input  logic [N_MST-1:0]    split_resume_i,
  output logic [N_MST-1:0]    m_grant_o,
  output logic [MW-1:0]       m_owner_o,
  output logic [DW-1:0]       m_rdata_o,
  output logic                m_ready_o,
  output logic [1:0]          m_resp_o,
  output logic [N_SLV-1:0]    s_sel_o,
  output logic [AW-1:0]       s_addr_o,
  output logic [1:0]          s_trans_o,
  output logic                s_write_o,
  output logic [DW-1:0]       s_wdata_o,
  input  logic [N_SLV*DW-1:0] s_rdata_i,
  input  logic [N_SLV-1:0]    s_ready_i,
  input  logic [N_SLV*2-1:0]  s_resp_i
);
  logic [N_MST-1:0] grant_w, split_set_w;
  logic [MW-1:0]    owner_w, dph_mst_w;
  logic             park_w, ready_w, a_write_w;
  logic [SW-1:0]    slv_idx_w;
  logic [N_SLV-1:0] sel_w;
  logic [AW-1:0]    a_addr_w;
  logic [1:0]       a_trans_w, resp_w;
  logic [DW-1:0]    wdata_w, rdata_w;

  bfab_arbiter #(.N_MST(N_MST), .MW(MW)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(m_req_i), .ready_i(ready_w),
    .split_set_i(split_set_w), .resume_i(split_resume_i),
    .grant_o(grant_w), .owner_o(owner_w), .park_o(park_w)
  );

  bfab_decoder #(.N_SLV(N_SLV), .AW(AW), .SW(SW)) u_dec (
    .addr_i(a_addr_w), .idx_o(slv_idx_w), .sel_o(sel_w)
  );

  bfab_datapath #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW), .MW(MW), .SW(SW)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .owner_i(owner_w), .park_i(park_w), .slv_idx_i(slv_idx_w),
    .m_addr_i(m_addr_i), .m_trans_i(m_trans_i), .m_write_i(m_write_i), .m_wdata_i(m_wdata_i),
    .s_rdata_i(s_rdata_i), .s_ready_i(s_ready_i), .s_resp_i(s_resp_i),
    .a_addr_o(a_addr_w), .a_trans_o(a_trans_w), .a_write_o(a_write_w), .wdata_o(wdata_w),
    .rdata_o(rdata_w), .ready_o(ready_w), .resp_o(resp_w), .split_set_o(split_set_w),
    .dph_mst_o(dph_mst_w)
  );

  // all outputs forced low while reset is held
  assign m_grant_o = rst_ni ? grant_w   : '0;
  assign m_owner_o = rst_ni ? owner_w   : '0;
  assign m_rdata_o = rst_ni ? rdata_w   : '0;
  assign m_ready_o = rst_ni ? ready_w   : 1'b0;
  assign m_resp_o  = rst_ni ? resp_w    : '0;
  assign s_sel_o   = rst_ni ? sel_w     : '0;
  assign s_addr_o  = rst_ni ? a_addr_w  : '0;
  assign s_trans_o = rst_ni ? a_trans_w : '0;
  assign s_write_o = rst_ni ? a_write_w : 1'b0;
  assign s_wdata_o = rst_ni ? wdata_w   : '0;
endmodule

// File: rtl/bus_fabric_chk.sv
module bus_fabric_chk #(
  parameter int N_MST = 3,
  parameter int N_SLV = 4,
  parameter int MW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] m_grant_o,
  input logic [MW-1:0]    m_owner_o,
  input logic             m_ready_o,
  input logic [1:0]       m_resp_o,
  input logic [N_SLV-1:0] s_sel_o,
  input logic [1:0]       s_trans_o,
  input logic [N_MST-1:0] split_resume_i,
  input logic             park_w,
  input logic [MW-1:0]    dph_mst_w
);
  assert_grant_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_grant_o));

  assert_grant_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_grant_o != '0) |-> m_grant_o[m_owner_o]);

  assert_hold_on_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_ready_o |=> $stable(m_grant_o) && $stable(m_owner_o));

  assert_park_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_w |-> (s_trans_o == 2'b00));

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_sel_o));

  assert_wdata_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(m_ready_o) |-> (dph_mst_w == $past(m_owner_o)));

  assert_split_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ready_o && m_resp_o == 2'b11 && !split_resume_i[dph_mst_w])
      |=> (!m_grant_o[$past(dph_mst_w)] || park_w));

  assert_reset_zero_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (m_grant_o == '0 && m_owner_o == '0 && !m_ready_o && m_resp_o == '0
                 && s_sel_o == '0 && s_trans_o == '0));
endmodule

bind bus_fabric bus_fabric_chk #(.N_MST(N_MST), .N_SLV(N_SLV), .MW(MW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .m_grant_o(m_grant_o), .m_owner_o(m_owner_o),
  .m_ready_o(m_ready_o), .m_resp_o(m_resp_o), .s_sel_o(s_sel_o), .s_trans_o(s_trans_o),
  .split_resume_i(split_resume_i), .park_w(park_w), .dph_mst_w(dph_mst_w)
);

// File: tb/bus_fabric_test.sv
`timescale 1ns/1ps
module bus_fabric_test;
  localparam int N_MST = 3;
  localparam int N_SLV = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MW = 2;

  // vector: master [23:20], address [19:4], expected slave [3:0]
  localparam logic [23:0] VEC [6] = '{
    {4'd0, 16'h0123, 4'd0}, {4'd1, 16'h4abc, 4'd1}, {4'd2, 16'h8000, 4'd2},
    {4'd0, 16'hffff, 4'd3}, {4'd2, 16'h3fff, 4'd0}, {4'd1, 16'hc004, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_MST-1:0]    m_req = '0;
  logic [N_MST*AW-1:0] m_addr = '0;
  logic [N_MST*2-1:0]  m_trans = '0;
  logic [N_MST-1:0]    m_write = '0;
  logic [N_MST*DW-1:0] m_wdata;
  logic [N_MST-1:0]    resume = '0;
  logic [N_MST-1:0]    grant;
  logic [MW-1:0]       owner;
  logic [DW-1:0]       rdata, s_wdata;
  logic                ready, s_write;
  logic [1:0]          resp, s_trans;
  logic [N_SLV-1:0]    sel;
  logic [AW-1:0]       s_addr;
  logic [N_SLV*DW-1:0] s_rdata;
  logic [N_SLV-1:0]    s_ready = '1;
  logic [N_SLV*2-1:0]  s_resp = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  assign s_rdata = {32'h5A00_0003, 32'h5A00_0002, 32'h5A00_0001, 32'h5A00_0000};
  assign m_wdata = {32'hD0D0_0002, 32'hD0D0_0001, 32'hD0D0_0000};

  always #2 clk = ~clk;

  bus_fabric #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .m_req_i(m_req), .m_addr_i(m_addr), .m_trans_i(m_trans),
    .m_write_i(m_write), .m_wdata_i(m_wdata), .split_resume_i(resume),
    .m_grant_o(grant), .m_owner_o(owner), .m_rdata_o(rdata), .m_ready_o(ready),
    .m_resp_o(resp), .s_sel_o(sel), .s_addr_o(s_addr), .s_trans_o(s_trans),
    .s_write_o(s_write), .s_wdata_o(s_wdata), .s_rdata_i(s_rdata), .s_ready_i(s_ready),
    .s_resp_i(s_resp)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    m_req = '0; m_trans = '0; m_write = '0;
    cyc(); cyc(); cyc();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset with busy inputs
    m_req = '1; m_trans = {N_MST{2'b10}}; m_addr = {N_MST{16'hc000}}; s_ready = '0; s_resp = '1;
    cyc(); cyc();
    chk("R10 grant", grant, 0);
    chk("R10 owner", owner, 0);
    chk("R10 ready", ready, 0);
    chk("R10 resp", resp, 0);
    chk("R10 sel", sel, 0);
    chk("R10 addr/trans", {s_addr, s_trans}, 0);
    chk("R10 data", {rdata, s_wdata}, 0);
    m_req = '0; m_trans = '0; m_addr = '0; s_ready = '1; s_resp = '0;
    rst_ni = 1'b1;
    cyc(); cyc();

    // R3 / R7: park with master 0 driving NONSEQ but not requesting
    m_trans[1:0] = 2'b10;
    cyc();
    chk("R3 park grant", grant, 3'b001);
    chk("R3 park trans idle", s_trans, 2'b00);
    chk("R7 idle ready", ready, 1);
    chk("R7 idle resp", resp, 0);
    chk("R7 idle rdata", rdata, 0);
    go_idle();

    // R1 R2 R5 R7: vector table
    for (int v = 0; v < 6; v++) begin
      automatic int mi = int'(VEC[v][23:20]);
      automatic int si = int'(VEC[v][3:0]);
      for (int j = 0; j < N_MST; j++) m_addr[j*AW +: AW] = 16'h2222;
      m_addr[mi*AW +: AW] = VEC[v][19:4];
      m_trans[mi*2 +: 2] = 2'b10;
      m_req[mi] = 1'b1;
      cyc();
      chk("R2 table grant", grant, 3'b001 << mi);
      chk("R2 table owner", owner, mi);
      chk("R1 table sel", sel, 4'b0001 << si);
      chk("R5 table addr", s_addr, VEC[v][19:4]);
      cyc();
      chk("R7 table rdata", rdata, 32'h5A00_0000 | si);
      go_idle();
    end

    // R2: priority
    m_req = 3'b110;
    cyc();
    chk("R2 prio 110", grant, 3'b010);
    m_req = 3'b111;
    cyc();
    chk("R2 prio 111", grant, 3'b001);
    chk("R2 prio owner", owner, 0);
    go_idle();

    // R6 / R5: overlapped phases between master 1 and master 0
    m_write = 3'b011;
    m_req = 3'b010; m_addr[1*AW +: AW] = 16'h4000; m_trans[3:2] = 2'b10;
    cyc();
    m_req = 3'b001; m_addr[0 +: AW] = 16'h8000; m_trans[1:0] = 2'b10;
    cyc();
    chk("R2 overlap owner", owner, 0);
    chk("R5 overlap addr", s_addr, 16'h8000);
    chk("R5 overlap write", s_write, 1);
    chk("R6 wdata from master1", s_wdata, 32'hD0D0_0001);
    cyc();
    chk("R6 wdata from master0", s_wdata, 32'hD0D0_0000);
    go_idle();

    // R4 / R7: slave 2 stalls
    m_req = 3'b010; m_addr[1*AW +: AW] = 16'h8000; m_trans[3:2] = 2'b10; s_ready[2] = 1'b0;
    cyc();
    cyc();
    chk("R7 stall ready low", ready, 0);
    m_req = 3'b011; m_trans[3:2] = 2'b00;
    cyc();
    chk("R4 grant held", grant, 3'b010);
    chk("R4 owner held", owner, 1);
    s_ready[2] = 1'b1;
    cyc();
    chk("R4 grant moves after ready", grant, 3'b001);
    go_idle();

    // R9: error response, no masking
    m_req = 3'b010; m_addr[1*AW +: AW] = 16'h4000; m_trans[3:2] = 2'b10; s_resp[3:2] = 2'b01;
    cyc();
    cyc();
    chk("R9 error resp", resp, 2'b01);
    cyc();
    chk("R9 still granted", grant, 3'b010);
    s_resp = '0;
    go_idle();

    // R8: split, hold, resume
    m_req = 3'b010; m_addr[1*AW +: AW] = 16'hc000; m_trans[3:2] = 2'b10; s_resp[7:6] = 2'b11;
    m_trans[1:0] = 2'b10;
    cyc();
    chk("R8 granted before split", grant, 3'b010);
    cyc();
    chk("R8 split resp", resp, 2'b11);
    cyc();
    chk("R8 masked, parked", grant, 3'b001);
    chk("R3 parked trans idle", s_trans, 2'b00);
    s_resp = '0;
    cyc();
    chk("R8 mask held", grant, 3'b001);
    resume[1] = 1'b1;
    cyc();
    resume[1] = 1'b0;
    chk("R8 resume grant", grant, 3'b010);
    chk("R8 resume owner", owner, 1);
    go_idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule